// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block steps through the clock states of the external bus transfers that make up one instruction of an 8-bit processor. A host stage loads a short list of machine cycles, such as an opcode fetch followed by memory reads, memory writes or port transfers, and pulses a start input. The sequencer then runs each listed cycle in turn. While it runs it drives a state code on the phase output, read and write strobes, a port-versus-memory select, and a done pulse at the end of every machine cycle. When the instruction ends it publishes the total count of clock states it used.

Every bus cycle has three states: address, strobe and transfer. An opcode fetch adds a fourth state in which the fetched code is decoded, and it may add further internal states for instructions that need extra execution time. A slow target holds the ready input low to stretch the strobe. Wait states are inserted only between the second and third states, and they last for as long as ready stays low. Instruction decoding, registers, arithmetic and address or data latching are outside this block. Only the strobe timing is produced.

Top module: `bus_cycle_seq`

## Requirements
- R1: After a synchronous active-low reset, the phase is idle (code 0), rd_stb, wr_stb, io_sel, mc_done, instr_done and busy are low, and t_total is 0.
- R2: A start pulse sampled while idle puts the sequencer in T1 on the next clock. It then runs the machine cycles in list order: entry k sits in mc_list bits [3k+2:3k]. The type codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 port read, 4 port write.
- R3: Every machine cycle passes T1 (code 1), T2 (code 2) and T3 (code 3), one clock each. An opcode fetch then adds T4 (code 4). Each other cycle ends in T3.
- R4: ready is sampled on the clock edge that ends T2 and on the edge that ends each wait state. While it is low, the next state is the wait state (code 5). The first high sample moves to T3.
- R5: rd_stb is high in T2, in every wait state and in T3 of cycle types 0, 1 and 3. wr_stb is high in the same states of types 2 and 4. Both strobes are low in T1, T4, the extra states and idle.
- R6: io_sel is high in every state of a type 3 or type 4 cycle and low in every other cycle.
- R7: With xtra_states = N, every opcode fetch has N extra internal states (code 6) after T4. The value is captured at start.
- R8: mc_done is high for exactly one clock, in the final state of each machine cycle. instr_done is high with it only in the final state of the last cycle. The state after that is idle.
- R9: One clock after instr_done, t_total holds the number of clock states the instruction used, including wait and extra states. It keeps that value until the next instruction completes.
- R10: An mc_num of 0 runs one cycle. An mc_num above 6 runs six cycles.
- R11: start, mc_num, mc_list and xtra_states have no effect while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period per clock state |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins an instruction when idle |
| mc_num | input | 3 | Number of machine cycles in the instruction |
| mc_list | input | 18 | Packed cycle type codes, entry 0 in the low bits |
| xtra_states | input | 2 | Extra internal states after each opcode fetch |
| ready | input | 1 | Target ready; low stretches the strobe |
| phase | output | 3 | Current state code |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| io_sel | output | 1 | High for port cycles, low for memory cycles |
| mc_done | output | 1 | Final state of a machine cycle |
| instr_done | output | 1 | Final state of the instruction |
| busy | output | 1 | Instruction in progress |
| t_total | output | 8 | Clock-state count of the last completed instruction |

## Verification
phase, the strobes, io_sel and both done flags are decoded from the state register. They are due one clock after the edge that sampled start or ready. t_total is due one clock after the instr_done state. The bench builds the expected state sequence of every instruction from its cycle list, wait placement and extra-state count. It drives inputs on the falling edge and compares every output on the falling edge of each state. Inputs are therefore stable at the rising edge, and each comparison reads the state that the previous edge produced. The bench reads t_total on the falling edge after the final state, when the sequencer is back to idle.

// File: rtl/bcs_pkg.sv
// Shared definitions for the bus cycle sequencer: state codes, cycle type
// codes and small classification helpers. Assumes type codes fit in 3 bits.
package bcs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4,
        PH_TW   = 3'd5,
        PH_TX   = 3'd6
    } phase_e;

    localparam logic [2:0] CY_FETCH = 3'd0;
    localparam logic [2:0] CY_MRD   = 3'd1;
    localparam logic [2:0] CY_MWR   = 3'd2;
    localparam logic [2:0] CY_IORD  = 3'd3;
    localparam logic [2:0] CY_IOWR  = 3'd4;

    // True for cycle types that move data toward the processor
    function automatic logic cyc_reads(input logic [2:0] t);
        return (t == CY_FETCH) || (t == CY_MRD) || (t == CY_IORD);
    endfunction

    // True for cycle types that move data away from the processor
    function automatic logic cyc_writes(input logic [2:0] t);
        return (t == CY_MWR) || (t == CY_IOWR);
    endfunction

    // True for port (non-memory) cycle types
    function automatic logic cyc_is_io(input logic [2:0] t);
        return (t == CY_IORD) || (t == CY_IOWR);
    endfunction

endpackage

// File: rtl/bcs_cycle_list.sv
// Holds the machine-cycle list of the running instruction and tracks which
// entry is current. Captures list and count on load; clamps the count to
// 1..MAX_CYC. Assumes advance is raised only while a cycle is ending.
module bcs_cycle_list #(
    parameter int MAX_CYC = 6,
    parameter int TYPE_W  = 3,
    localparam int NUM_W  = $clog2(MAX_CYC + 1),
    localparam int IDX_W  = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1,
    localparam int LIST_W = MAX_CYC * TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [NUM_W-1:0]  num_in,
    input  logic [LIST_W-1:0] list_in,
    output logic [TYPE_W-1:0] cur_type,
    output logic              is_last
);

    logic [LIST_W-1:0] list_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic [NUM_W-1:0]  eff_num;
    logic [NUM_W-1:0]  eff_m1;
    logic [TYPE_W-1:0] entry [MAX_CYC];

    // Clamp the requested count into the supported range
    always_comb begin
        if (num_in == '0)
            eff_num = NUM_W'(1);
        else if (num_in > NUM_W'(MAX_CYC))
            eff_num = NUM_W'(MAX_CYC);
        else
            eff_num = num_in;
        eff_m1 = eff_num - NUM_W'(1);
    end

    // Unpack the stored list into per-entry type codes
    for (genvar g = 0; g < MAX_CYC; g++) begin : g_entry
        assign entry[g] = list_q[g*TYPE_W +: TYPE_W];
    end

    // Capture the list on load and step the index at each cycle end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            list_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (load) begin
            list_q <= list_in;
            idx_q  <= '0;
            last_q <= eff_m1[IDX_W-1:0];
        end else if (advance) begin
            idx_q  <= idx_q + IDX_W'(1);
        end
    end

    assign cur_type = entry[idx_q];
    assign is_last  = (idx_q == last_q);

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load |=> idx_q == $past(idx_q) + IDX_W'(1));

endmodule

// File: rtl/bcs_phase_fsm.sv
// Clock-state machine for one instruction: walks T1, T2, wait, T3, T4 and
// extra internal states per cycle, signalling cycle and instruction end.
// Assumes cur_type and is_last come from the cycle list of this instruction.
module bcs_phase_fsm
    import bcs_pkg::*;
#(
    parameter int TYPE_W = 3,
    parameter int XTRA_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ready,
    input  logic [XTRA_W-1:0] xtra_in,
    input  logic [TYPE_W-1:0] cur_type,
    input  logic              is_last,
    output phase_e            phase,
    output logic              load,
    output logic              advance,
    output logic              mc_done,
    output logic              instr_done,
    output logic              busy
);

    phase_e            ph_q, ph_d;
    logic [XTRA_W-1:0] xtra_q;
    logic [XTRA_W-1:0] xcnt_q, xcnt_d;
    logic              is_fetch;

    assign is_fetch = (cur_type == TYPE_W'(CY_FETCH));

    // Decide whether the current state is the last one of its machine cycle
    always_comb begin
        case (ph_q)
            PH_T3:   mc_done = !is_fetch;
            PH_T4:   mc_done = (xtra_q == '0);
            PH_TX:   mc_done = (xcnt_q == xtra_q);
            default: mc_done = 1'b0;
        endcase
    end

    assign instr_done = mc_done && is_last;
    assign advance    = mc_done && !is_last;
    assign load       = (ph_q == PH_IDLE) && start;
    assign busy       = (ph_q != PH_IDLE);
    assign phase      = ph_q;

    // Next-state selection for the clock-state walk
    always_comb begin
        ph_d   = ph_q;
        xcnt_d = xcnt_q;
        case (ph_q)
            PH_IDLE: if (start) ph_d = PH_T1;
            PH_T1:   ph_d = PH_T2;
            PH_T2:   ph_d = ready ? PH_T3 : PH_TW;
            PH_TW:   ph_d = ready ? PH_T3 : PH_TW;
            PH_T3:   ph_d = is_fetch ? PH_T4 : PH_T1;
            PH_T4: begin
                if (xtra_q != '0) begin
                    ph_d   = PH_TX;
                    xcnt_d = XTRA_W'(1);
                end else begin
                    ph_d = PH_T1;
                end
            end
            PH_TX: begin
                if (xcnt_q == xtra_q) ph_d = PH_T1;
                else                  xcnt_d = xcnt_q + XTRA_W'(1);
            end
            default: ph_d = PH_IDLE;
        endcase
        if (instr_done) ph_d = PH_IDLE;
    end

    // State, extra-state counter and captured extra-state count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            xcnt_q <= '0;
            xtra_q <= '0;
        end else begin
            ph_q   <= ph_d;
            xcnt_q <= xcnt_d;
            if (load) xtra_q <= xtra_in;
        end
    end

    // R3
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q == PH_T1 |=> ph_q == PH_T2);
    // R4
    wait_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_T2 || ph_q == PH_TW) && !ready |=> ph_q == PH_TW);
    // R4
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_T2 || ph_q == PH_TW) && ready |=> ph_q == PH_T3);
    // R8
    cycle_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mc_done && !instr_done |=> ph_q == PH_T1);
    // R8
    instr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> ph_q == PH_IDLE);
    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !instr_done |=> busy);

endmodule

// File: rtl/bcs_tcount.sv
// Counts the clock states of the running instruction and publishes the
// total when it ends. Saturates at the counter maximum under long waits.
module bcs_tcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             busy,
    input  logic             instr_done,
    output logic [CNT_W-1:0] t_total
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + CNT_W'(1);

    // Running count and published total
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            t_total <= '0;
        end else begin
            if (load)      cnt_q <= '0;
            else if (busy) cnt_q <= cnt_inc;
            if (instr_done) t_total <= cnt_inc;
        end
    end

    // R9
    total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_done |=> $stable(t_total));

endmodule

// File: rtl/bus_cycle_seq.sv
// Top of the bus cycle sequencer: joins the cycle list, the clock-state
// machine and the state counter, and decodes strobes and port select from
// the current state and cycle type. Assumes one clock per clock state.
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int MAX_CYC = 6,
    parameter int TYPE_W  = 3,
    parameter int XTRA_W  = 2,
    parameter int CNT_W   = 8,
    localparam int NUM_W  = $clog2(MAX_CYC + 1),
    localparam int LIST_W = MAX_CYC * TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_W-1:0]  mc_num,
    input  logic [LIST_W-1:0] mc_list,
    input  logic [XTRA_W-1:0] xtra_states,
    input  logic              ready,
    output logic [2:0]        phase,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              io_sel,
    output logic              mc_done,
    output logic              instr_done,
    output logic              busy,
    output logic [CNT_W-1:0]  t_total
);

    phase_e            ph;
    logic              load;
    logic              advance;
    logic              is_last;
    logic [TYPE_W-1:0] cur_type;
    logic              bus_ph;

    bcs_cycle_list #(.MAX_CYC(MAX_CYC), .TYPE_W(TYPE_W)) u_list (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .num_in   (mc_num),
        .list_in  (mc_list),
        .cur_type (cur_type),
        .is_last  (is_last)
    );

    bcs_phase_fsm #(.TYPE_W(TYPE_W), .XTRA_W(XTRA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ready      (ready),
        .xtra_in    (xtra_states),
        .cur_type   (cur_type),
        .is_last    (is_last),
        .phase      (ph),
        .load       (load),
        .advance    (advance),
        .mc_done    (mc_done),
        .instr_done (instr_done),
        .busy       (busy)
    );

    bcs_tcount #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .busy       (busy),
        .instr_done (instr_done),
        .t_total    (t_total)
    );

    // Strobe window and port select decoded from state and cycle type
    always_comb begin
        bus_ph = (ph == PH_T2) || (ph == PH_TW) || (ph == PH_T3);
        rd_stb = bus_ph && cyc_reads(cur_type[2:0]);
        wr_stb = bus_ph && cyc_writes(cur_type[2:0]);
        io_sel = busy && cyc_is_io(cur_type[2:0]);
    end

    assign phase = ph;

    // R5
    strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_stb) || $fell(wr_stb) |-> ph == PH_T4 || ph == PH_T1 || ph == PH_IDLE);
    // R5
    strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_stb) || $rose(wr_stb) |-> $past(ph) == PH_T1);
    // R6
    io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel && !mc_done |=> io_sel);

endmodule

// File: tb/bus_cycle_seq_bench.sv
// Self-checking bench: walks a table of instruction vectors, modelling the
// expected state sequence, then runs directed reset and corner-case tests.
module bus_cycle_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    typedef struct packed {
        logic [2:0]  num;
        logic [17:0] list;
        logic [1:0]  xtra;
        logic [2:0]  wmc;
        logic [3:0]  waits;
        logic [7:0]  total;
    } vec_t;

    // num, list (octal digit k = entry k), extra, wait cycle, waits, total
    localparam vec_t VECS [NVEC] = '{
        '{3'd2, 18'o000010, 2'd0, 3'd0, 4'd0, 8'd7 },
        '{3'd3, 18'o000110, 2'd0, 3'd0, 4'd0, 8'd10},
        '{3'd2, 18'o000020, 2'd0, 3'd0, 4'd0, 8'd7 },
        '{3'd5, 18'o022110, 2'd2, 3'd0, 4'd0, 8'd18},
        '{3'd3, 18'o000310, 2'd0, 3'd2, 4'd2, 8'd12},
        '{3'd3, 18'o000410, 2'd0, 3'd0, 4'd1, 8'd11},
        '{3'd6, 18'o221110, 2'd1, 3'd4, 4'd3, 8'd23},
        '{3'd0, 18'o000000, 2'd0, 3'd0, 4'd0, 8'd4 },
        '{3'd7, 18'o111110, 2'd0, 3'd0, 4'd0, 8'd19}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mc_num = 3'd0;
    logic [17:0] mc_list = '0;
    logic [1:0]  xtra_states = 2'd0;
    logic        ready = 1'b1;
    logic [2:0]  phase;
    logic        rd_stb, wr_stb, io_sel, mc_done, instr_done, busy;
    logic [7:0]  t_total;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    bus_cycle_seq u_bus_cycle_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mc_num      (mc_num),
        .mc_list     (mc_list),
        .xtra_states (xtra_states),
        .ready       (ready),
        .phase       (phase),
        .rd_stb      (rd_stb),
        .wr_stb      (wr_stb),
        .io_sel      (io_sel),
        .mc_done     (mc_done),
        .instr_done  (instr_done),
        .busy        (busy),
        .t_total     (t_total)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Run one instruction and compare every state; optionally disturb inputs mid-run (R11)
    task automatic run_vec(input vec_t v, input bit disturb);
        int eff, seen, t, w, nst, ph, exp_rd, exp_wr, exp_io, bus;
        eff = (v.num == 0) ? 1 : ((v.num > 6) ? 6 : int'(v.num));
        seen = 0;
        mc_num = v.num; mc_list = v.list; xtra_states = v.xtra;
        ready = 1'b1; start = 1'b1;
        for (int k = 0; k < eff; k++) begin
            t = int'(v.list[3*k +: 3]);
            w = (k == int'(v.wmc)) ? int'(v.waits) : 0;
            nst = ((t == 0) ? 4 + int'(v.xtra) : 3) + w;
            for (int s = 0; s < nst; s++) begin
                @(negedge clk);
                seen++;
                if (disturb && seen == 4) begin
                    start = 1'b1; mc_num = 3'd6; mc_list = '0; xtra_states = 2'd3;
                end else begin
                    start = 1'b0;
                end
                if (s == 0)          ph = 1;
                else if (s == 1)     ph = 2;
                else if (s <= 1 + w) ph = 5;
                else if (s == 2 + w) ph = 3;
                else if (s == 3 + w) ph = 4;
                else                 ph = 6;
                bus = (ph == 2 || ph == 3 || ph == 5) ? 1 : 0;
                exp_rd = (bus == 1 && (t == 0 || t == 1 || t == 3)) ? 1 : 0;
                exp_wr = (bus == 1 && (t == 2 || t == 4)) ? 1 : 0;
                exp_io = (t == 3 || t == 4) ? 1 : 0;
                if (ph == 5)      chk("R4 phase wait", int'(phase), ph);
                else if (ph == 6) chk("R7 phase extra", int'(phase), ph);
                else              chk("R3 phase", int'(phase), ph);
                chk("R5 rd_stb", int'(rd_stb), exp_rd);
                chk("R5 wr_stb", int'(wr_stb), exp_wr);
                chk("R6 io_sel", int'(io_sel), exp_io);
                chk("R8 mc_done", int'(mc_done), (s == nst - 1) ? 1 : 0);
                chk("R8 instr_done", int'(instr_done),
                    (s == nst - 1 && k == eff - 1) ? 1 : 0);
                if (ph == 2)      ready = (w == 0);
                else if (ph == 5) ready = (s - 1 == w);
                else              ready = 1'b1;
            end
        end
        start = 1'b0;
        @(negedge clk);
        chk("R8 idle after end", int'(phase), 0);
        chk("R2 busy low", int'(busy), 0);
        chk("R9 t_total", int'(t_total), int'(v.total));
        chk("R10 state count", seen, int'(v.total));
        if (disturb) begin
            @(negedge clk);
            chk("R11 no restart", int'(phase), 0);
            chk("R11 total kept", int'(t_total), int'(v.total));
        end
    endtask

    // Watchdog: an expired limit is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog: got 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 phase", int'(phase), 0);
        chk("R1 rd_stb", int'(rd_stb), 0);
        chk("R1 wr_stb", int'(wr_stb), 0);
        chk("R1 io_sel", int'(io_sel), 0);
        chk("R1 mc_done", int'(mc_done), 0);
        chk("R1 instr_done", int'(instr_done), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 t_total", int'(t_total), 0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 1'b0);

        // R9: total holds while idle
        repeat (3) @(negedge clk);
        chk("R9 hold while idle", int'(t_total), int'(VECS[NVEC-1].total));

        // R11: inputs changed while busy are ignored
        run_vec(VECS[1], 1'b1);
        run_vec(VECS[3], 1'b1);

        // R1: reset mid-instruction returns to the reset state
        mc_num = 3'd3; mc_list = 18'o000110; xtra_states = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 phase after reset", int'(phase), 0);
        chk("R1 t_total after reset", int'(t_total), 0);
        chk("R1 rd_stb after reset", int'(rd_stb), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule